// File: doc/BRIEF.md
# Cascaded Programmable Interrupt Controller

The block holds two 8-line interrupt controllers, a primary and a secondary. The secondary's interrupt output drives one line of the primary, the cascade line. The primary's output is the block's single interrupt pin. Each controller captures requests in a request register. Each line captures on a rising edge or follows the level, as set in one of two sense registers. Each controller also has an 8-bit mask. Priority resolution is not built. Once software sets the special mask mode through a command byte, a controller raises its output whenever any captured request is unmasked.

Software reaches the block through a plain register port. A 2-bit unit select picks the primary, the secondary or the sense registers, and a 1-bit address picks the command port or the data port within the unit. Write and read strobes are synchronous, one cycle wide. Read data is registered. An interrupt service routine reads the request register to find the active lines. It then ends with a specific end-of-interrupt command naming the line, which drops that line's edge capture.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset both masks read 0xFF, both sense registers read 0x00 (all lines edge-captured), both request registers read 0x00, special mask mode is off and irq_out is low.
- R2: For a line in edge mode, a 0-to-1 change seen at a clock edge sets its request bit. The bit stays set after the input drops and is visible in the request register.
- R3: For a line in level mode, the request bit equals the input as sampled at the previous clock edge. It clears when the input drops, with no end-of-interrupt needed.
- R4: A command-port write of 0x60|n (bits 7:5 = 011, bits 4:3 = 00, line n in bits 2:0) clears edge request bit n of that controller and no other bit.
- R5: A mask bit of 1 keeps that request from the output without clearing the request bit. Clearing the mask bit lets the request reach the output again right after the write edge.
- R6: A command byte with bits 4:3 = 01 and bit 6 = 1 loads special mask mode from bit 5 (0x6a sets it, 0x4a clears it). While it is set, the controller output is the OR of unmasked request bits. While it is clear, the output is low.
- R7: The secondary's output feeds primary line CASC_LINE (default 2), ORed with irq_mst[CASC_LINE]. That line is always level-sensed, whatever its sense bit holds. A secondary request reaches irq_out two clock edges after its input rises.
- R8: A command byte with bits 4:3 = 01 and bit 1 = 1 loads the read select from bit 0. With 0, command-port reads return the request register. With 1 (in-service select), they return 0x00. Data-port reads return the mask. bus_rdata carries the value from the edge of the read strobe and holds it until the next read.
- R9: Unit 2 holds the sense registers: address 0 for the primary and address 1 for the secondary, 1 = level and 0 = edge per line. They read back as written. Unit 3 reads 0x00 and ignores writes.
- R10: A command byte matching neither pattern above (bit 4 set, or bits 4:3 = 00 with bits 7:5 other than 011) changes no request bit, mask or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_mst | input | 8 | Request inputs of the primary controller |
| irq_slv | input | 8 | Request inputs of the secondary controller |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_unit | input | 2 | 0 primary, 1 secondary, 2 sense registers, 3 none |
| bus_addr | input | 1 | 0 command port, 1 data (mask) port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt output of the primary controller |

## Verification
A primary line's request bit and irq_out change one clock edge after its input changes. A secondary line takes a second edge to pass through the cascade line. Mask, mode and end-of-interrupt writes act on irq_out right after the write edge, and a cascaded clear needs one edge more. The bench drives inputs one time unit after a rising edge and counts the edges it waits before sampling. It inserts the extra edge for every secondary line. It reads request registers through the port, where the data belongs to the edge of the read strobe. The sweep covers every line in both sense modes, with expected bit patterns computed from the line number.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [1:0] {
    UNIT_MST   = 2'd0,
    UNIT_SLV   = 2'd1,
    UNIT_SENSE = 2'd2,
    UNIT_NONE  = 2'd3
  } cic_unit_e;

  typedef struct packed {
    logic             eoi;
    logic [IDX_W-1:0] eoi_idx;
    logic             smm_we;
    logic             smm_val;
    logic             rsel_we;
    logic             rsel_isr;
  } cic_cmd_t;

  function automatic cic_cmd_t cic_decode(input logic [7:0] b);
    cic_cmd_t c;
    c = '0;
    if (b[4:3] == 2'b01) begin
      c.smm_we   = b[6];
      c.smm_val  = b[5];
      c.rsel_we  = b[1];
      c.rsel_isr = b[0];
    end else if (b[4:3] == 2'b00 && b[7:5] == 3'b011) begin
      c.eoi     = 1'b1;
      c.eoi_idx = b[IDX_W-1:0];
    end
    return c;
  endfunction

endpackage

// File: rtl/cic_req_bank.sv
module cic_req_bank #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] edge_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] irr_o
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] irr_q;
  logic [LINES-1:0] rise;

  assign rise  = req_i & ~prev_q;
  assign irr_o = irr_q;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[gi] <= 1'b0;
        irr_q[gi]  <= 1'b0;
      end else begin
        prev_q[gi] <= req_i[gi];
        if (edge_i[gi]) irr_q[gi] <= (irr_q[gi] & ~clr_i[gi]) | rise[gi];
        else            irr_q[gi] <= req_i[gi];
      end
    end

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i[gi] && req_i[gi] && !prev_q[gi]) |=> irr_q[gi]); // R2
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i[gi] && irr_q[gi] && !clr_i[gi]) |=> irr_q[gi]); // R2
    AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i[gi] && clr_i[gi] && !(req_i[gi] && !prev_q[gi])) |=> !irr_q[gi]); // R4
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_i[gi] |=> (irr_q[gi] == $past(req_i[gi]))); // R3
  end

endmodule

// File: rtl/cic_unit.sv
module cic_unit
  import cic_pkg::*;
#(
  parameter logic [LINES-1:0] FORCE_LEVEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] edge_i,
  input  logic             wr_cmd_i,
  input  logic             wr_mask_i,
  input  logic [7:0]       wdata_i,
  output logic             irq_o,
  output logic [LINES-1:0] irr_o,
  output logic [7:0]       rd_cmd_o,
  output logic [7:0]       mask_o
);

  cic_cmd_t         cmd;
  logic             smm_q;
  logic             rsel_q;
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] edge_eff;
  logic [LINES-1:0] irr;

  assign cmd      = cic_decode(wdata_i);
  assign edge_eff = edge_i & ~FORCE_LEVEL;

  always_comb begin
    clr = '0;
    if (wr_cmd_i && cmd.eoi) clr[cmd.eoi_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      mask_q <= '1;
    end else begin
      if (wr_cmd_i && cmd.smm_we)  smm_q  <= cmd.smm_val;
      if (wr_cmd_i && cmd.rsel_we) rsel_q <= cmd.rsel_isr;
      if (wr_mask_i)               mask_q <= wdata_i;
    end
  end

  cic_req_bank #(.LINES(LINES)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .edge_i(edge_eff),
    .clr_i (clr),
    .irr_o (irr)
  );

  assign irq_o    = smm_q & |(irr & ~mask_q);
  assign irr_o    = irr;
  assign rd_cmd_o = rsel_q ? 8'h00 : irr;
  assign mask_o   = mask_q;

  AST_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_i && !cmd.eoi && !cmd.smm_we && !cmd.rsel_we) |=> ($stable(smm_q) && $stable(rsel_q))); // R10
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask_i |=> $stable(mask_q)); // R5

endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl
  import cic_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_mst,
  input  logic [7:0] irq_slv,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_unit,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_out
);

  localparam logic [LINES-1:0] CASC_MASK = LINES'(1) << CASC_LINE;

  logic [7:0] sense_m_q, sense_s_q;
  logic [7:0] m_req;
  logic       slv_irq;
  logic [7:0] m_irr, s_irr;
  logic [7:0] m_rd_cmd, s_rd_cmd, m_mask, s_mask;
  logic [7:0] rd_mux;
  logic       sel_m, sel_s, sel_sense;

  assign sel_m     = bus_unit == UNIT_MST;
  assign sel_s     = bus_unit == UNIT_SLV;
  assign sel_sense = bus_unit == UNIT_SENSE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_m_q <= '0;
      sense_s_q <= '0;
    end else if (bus_wr && sel_sense) begin
      if (bus_addr) sense_s_q <= bus_wdata;
      else          sense_m_q <= bus_wdata;
    end
  end

  always_comb begin
    m_req            = irq_mst;
    m_req[CASC_LINE] = irq_mst[CASC_LINE] | slv_irq;
  end

  cic_unit #(.FORCE_LEVEL('0)) u_slv (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (irq_slv),
    .edge_i   (~sense_s_q),
    .wr_cmd_i (bus_wr && sel_s && !bus_addr),
    .wr_mask_i(bus_wr && sel_s && bus_addr),
    .wdata_i  (bus_wdata),
    .irq_o    (slv_irq),
    .irr_o    (s_irr),
    .rd_cmd_o (s_rd_cmd),
    .mask_o   (s_mask)
  );

  cic_unit #(.FORCE_LEVEL(CASC_MASK)) u_mst (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (m_req),
    .edge_i   (~sense_m_q),
    .wr_cmd_i (bus_wr && sel_m && !bus_addr),
    .wr_mask_i(bus_wr && sel_m && bus_addr),
    .wdata_i  (bus_wdata),
    .irq_o    (irq_out),
    .irr_o    (m_irr),
    .rd_cmd_o (m_rd_cmd),
    .mask_o   (m_mask)
  );

  always_comb begin
    unique case (bus_unit)
      UNIT_MST:   rd_mux = bus_addr ? m_mask : m_rd_cmd;
      UNIT_SLV:   rd_mux = bus_addr ? s_mask : s_rd_cmd;
      UNIT_SENSE: rd_mux = bus_addr ? sense_s_q : sense_m_q;
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_CASC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    slv_irq |=> m_irr[CASC_LINE]); // R7
  AST_SLV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_irr == 8'h00) |-> !slv_irq); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R8
  AST_SENSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_sense) |=> ($stable(sense_m_q) && $stable(sense_s_q))); // R9

endmodule

// File: tb/sim_cascaded_irq_ctrl.sv
module sim_cascaded_irq_ctrl;
  localparam int CASC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [1:0] bus_unit = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_out;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascaded_irq_ctrl #(.CASC_LINE(CASC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_mst(pins[7:0]), .irq_slv(pins[15:8]),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_unit(bus_unit), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] u, input logic a, input logic [7:0] d);
    bus_unit = u; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] u, input logic a, output logic [7:0] d);
    bus_unit = u; bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    end
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(0, 1, d); chk("R1 primary mask", d, 8'hFF);
    rd(1, 1, d); chk("R1 secondary mask", d, 8'hFF);
    rd(2, 0, d); chk("R1 primary sense", d, 8'h00);
    rd(2, 1, d); chk("R1 secondary sense", d, 8'h00);
    rd(0, 0, d); chk("R1 primary irr", d, 8'h00);
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);

    // R6 output gated while special mask mode off
    wr(0, 1, 8'h00);
    wr(1, 1, 8'h00);
    pins[0] = 1'b1; tick(); pins[0] = 1'b0; tick();
    rd(0, 0, d); chk("R2 latch without smm", d, 8'h01);
    chk("R6 out low without smm", {7'd0, irq_out}, 8'h00);
    wr(0, 0, 8'h6a);
    chk("R6 out after 0x6a", {7'd0, irq_out}, 8'h01);
    wr(0, 0, 8'h60);
    chk("R4 out after eoi", {7'd0, irq_out}, 8'h00);
    wr(1, 0, 8'h6a);

    // edge sweep over all lines (R2 R4 R7)
    for (int l = 0; l < 16; l++) begin
      logic [1:0] u;
      if (l == CASC) continue;
      u = (l >= 8) ? 2'd1 : 2'd0;
      pins[l] = 1'b1; tick(); pins[l] = 1'b0; tick(); tick();
      rd(u, 0, d); chk($sformatf("R2 edge line %0d", l), d, 8'(1 << (l % 8)));
      if (l >= 8) begin
        rd(0, 0, d); chk($sformatf("R7 cascade bit line %0d", l), d, 8'(1 << CASC));
      end
      chk($sformatf("R6 out line %0d", l), {7'd0, irq_out}, 8'h01);
      wr(u, 0, 8'(8'h60 | (l % 8)));
      tick();
      rd(u, 0, d); chk($sformatf("R4 eoi line %0d", l), d, 8'h00);
      chk($sformatf("R4 out clear line %0d", l), {7'd0, irq_out}, 8'h00);
    end

    // level sweep (R3 R9)
    wr(2, 0, 8'hFF); wr(2, 1, 8'hFF);
    rd(2, 0, d); chk("R9 sense readback", d, 8'hFF);
    for (int l = 0; l < 16; l++) begin
      logic [1:0] u;
      if (l == CASC) continue;
      u = (l >= 8) ? 2'd1 : 2'd0;
      pins[l] = 1'b1; tick(); tick();
      rd(u, 0, d); chk($sformatf("R3 level high line %0d", l), d, 8'(1 << (l % 8)));
      chk($sformatf("R3 out high line %0d", l), {7'd0, irq_out}, 8'h01);
      pins[l] = 1'b0; tick(); tick();
      rd(u, 0, d); chk($sformatf("R3 level low line %0d", l), d, 8'h00);
      chk($sformatf("R3 out low line %0d", l), {7'd0, irq_out}, 8'h00);
    end
    wr(2, 0, 8'h00); wr(2, 1, 8'h00);
    wr(2, 0, 8'hA5); rd(2, 0, d); chk("R9 primary sense A5", d, 8'hA5);
    wr(2, 1, 8'h3C); rd(2, 1, d); chk("R9 secondary sense 3C", d, 8'h3C);
    wr(3, 0, 8'hFF); rd(3, 0, d); chk("R9 unit3 reads zero", d, 8'h00);
    rd(2, 0, d); chk("R9 unit3 write ignored", d, 8'hA5);
    wr(2, 0, 8'h00); wr(2, 1, 8'h00);

    // R5 mask holds latch
    pins[5] = 1'b1; tick(); pins[5] = 1'b0; tick();
    wr(0, 1, 8'h20);
    chk("R5 masked out low", {7'd0, irq_out}, 8'h00);
    rd(0, 0, d); chk("R5 latch kept", d, 8'h20);
    wr(0, 1, 8'h00);
    chk("R5 unmask restores", {7'd0, irq_out}, 8'h01);
    wr(0, 0, 8'h65);

    // R4 selectivity
    pins[1] = 1'b1; pins[3] = 1'b1; tick(); pins[1] = 1'b0; pins[3] = 1'b0; tick();
    wr(0, 0, 8'h63);
    rd(0, 0, d); chk("R4 only line3 cleared", d, 8'h02);

    // R8 read select
    wr(0, 0, 8'h0b); rd(0, 0, d); chk("R8 isr reads zero", d, 8'h00);
    wr(0, 0, 8'h0a); rd(0, 0, d); chk("R8 irr select", d, 8'h02);
    rd(0, 1, d); chk("R8 data port mask", d, 8'h00);

    // R10 inert commands
    wr(0, 0, 8'h13); rd(0, 0, d); chk("R10 bit4 cmd irr", d, 8'h02);
    chk("R10 bit4 cmd out", {7'd0, irq_out}, 8'h01);
    wr(0, 0, 8'h21); rd(0, 0, d); chk("R10 nonspecific eoi irr", d, 8'h02);
    rd(0, 1, d); chk("R10 mask unchanged", d, 8'h00);

    // R6 clear special mask mode
    wr(0, 0, 8'h4a);
    chk("R6 0x4a drops out", {7'd0, irq_out}, 8'h00);
    wr(0, 0, 8'h6a);
    chk("R6 0x6a restores", {7'd0, irq_out}, 8'h01);
    wr(0, 0, 8'h61);

    // R7 cascade pin and mask
    pins[CASC] = 1'b1; tick(); tick();
    chk("R7 primary pin on cascade line", {7'd0, irq_out}, 8'h01);
    pins[CASC] = 1'b0; tick(); tick();
    chk("R7 cascade pin level drop", {7'd0, irq_out}, 8'h00);
    wr(0, 1, 8'(1 << CASC));
    pins[12] = 1'b1; tick(); pins[12] = 1'b0; tick(); tick();
    chk("R7 cascade masked", {7'd0, irq_out}, 8'h00);
    wr(0, 1, 8'h00);
    chk("R7 cascade unmasked", {7'd0, irq_out}, 8'h01);

    summary();
  end
endmodule